// File: doc/BRIEF.md
# Raster Line/Frame Sequencer

The block turns the system clock into horizontal line ticks and keeps track of which scanline of a video frame is being scanned. It supports two selectable video standards, each with its own line total and frame length. Line periods are not a whole number of clocks. A fixed-point phase accumulator spreads the fractional part evenly across the lines. The frame boundary is pinned to an exact clock count, so rounding error never accumulates from one frame to the next.

When the scanline counter reaches the vertical blank line, the block raises a vblank flag and a one-cycle interrupt pulse, and it clears a line-parity flag in its status word. When the frame ends, the line count returns to zero, vblank drops and the frame counter advances. In interlaced operation the field indicator then follows the new frame parity. The field is shown in the status word, and it is also folded into the parity flag. The standard select is sampled only at a frame boundary.

Top module: `raster_frame_seq`

## Requirements
- R1: While `rst` is high, on every clock edge the block forces `line_num`, `frame_cnt`, `field`, `vblank`, `vbl_irq`, `hsync_tick` and `status_word` to zero.
- R2: Every line L, for 1 <= L < total, begins on clock edge ceil(L * INC / 2^FRAC_W) counted from the start of the frame. INC is the increment of the active standard. `hsync_tick` is high for exactly the cycle in which `line_num` takes a new value.
- R3: The last line of a frame ends on clock edge FRAME_CLK of the active standard, counted from the start of the frame. On that edge `line_num` returns to 0 and `hsync_tick` is high.
- R4: A frame has LINES_A lines (0 to LINES_A-1) when the latched standard is 0, and LINES_B lines when it is 1.
- R5: `vblank` rises on the cycle in which `line_num` becomes VBL_LINE and stays high until the frame wrap, which clears it.
- R6: `vbl_irq` is a single-cycle pulse, issued only in the cycle in which `line_num` becomes VBL_LINE.
- R7: `frame_cnt` increments by one at each frame wrap, wraps modulo 2^FRAME_W, and holds at all other times.
- R8: At a frame wrap, `field` takes bit 0 of the new frame count if `ilace_en` equals 2'b11, and 0 otherwise. Status bit 31 always equals `field`.
- R9: Status bit 13 (line parity) is cleared when vblank starts. At a frame wrap it is XORed with the new field value. All other status bits read 0.
- R10: A change of `std_sel` in the middle of a frame does not alter that frame's line timing. It takes effect from the frame that starts at the next wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| std_sel | input | 1 | Video standard select (0: standard A, 1: standard B) |
| ilace_en | input | 2 | Interlace enables; both set enables field toggling |
| hsync_tick | output | 1 | One-cycle pulse when a new line starts |
| line_num | output | LINE_W | Current scanline in the frame |
| vblank | output | 1 | Vertical blank active |
| vbl_irq | output | 1 | One-cycle vblank-start interrupt |
| field | output | 1 | Odd/even field indicator |
| frame_cnt | output | FRAME_W | Frame counter |
| status_word | output | 32 | Status: bit 31 field, bit 13 line parity |

## Verification
The assertions assume parameters under which the accumulator ends every line except the last before the frame clock count expires. In other words, ceil((total-1)*INC/2^FRAC_W) must be smaller than FRAME_CLK for both standards. The bench uses small standards (10 and 12 lines, 5.5 and 6.25 clocks per line) that meet this with a margin, so that every frame can be followed to the cycle. The inputs `std_sel` and `ilace_en` are unconstrained. The bench changes them both at frame starts and mid-frame, and it pulses reset in the middle of a frame.

// File: rtl/raster_seq_pkg.sv
package raster_seq_pkg;

  typedef enum logic {
    STD_A = 1'b0,
    STD_B = 1'b1
  } vstd_e;

  localparam int STAT_W          = 32;
  localparam int STAT_FIELD_BIT  = 31;
  localparam int STAT_PARITY_BIT = 13;

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/raster_line_timer.sv
// Fixed-point line-period generator with an exact frame-length resync.
module raster_line_timer #(
  parameter int FRAC_W      = 12,
  parameter int INC_A       = 8791293,
  parameter int INC_B       = 8836089,
  parameter int FRAME_CLK_A = 564480,
  parameter int FRAME_CLK_B = 677376,
  parameter int PH_W        = 25,
  parameter int FC_W        = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic std_b,
  input  logic last_line,
  output logic line_adv,
  output logic frame_end
);

  localparam logic [PH_W:0]   STEP      = {{PH_W{1'b0}}, 1'b1} << FRAC_W;
  localparam logic [PH_W:0]   INC_A_V   = (PH_W+1)'(INC_A);
  localparam logic [PH_W:0]   INC_B_V   = (PH_W+1)'(INC_B);
  localparam logic [FC_W-1:0] FC_LAST_A = FC_W'(FRAME_CLK_A - 1);
  localparam logic [FC_W-1:0] FC_LAST_B = FC_W'(FRAME_CLK_B - 1);

  logic [PH_W-1:0] phase_q;
  logic [FC_W-1:0] fclk_q;
  logic [PH_W:0]   phase_sum;
  logic [PH_W:0]   inc_v;
  logic [FC_W-1:0] fc_last;

  always_comb begin
    inc_v     = std_b ? INC_B_V : INC_A_V;
    fc_last   = std_b ? FC_LAST_B : FC_LAST_A;
    phase_sum = {1'b0, phase_q} + STEP;
    line_adv  = !last_line && (phase_sum >= inc_v);
    frame_end = last_line && (fclk_q == fc_last);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
      fclk_q  <= '0;
    end else if (frame_end) begin
      phase_q <= '0;
      fclk_q  <= '0;
    end else begin
      fclk_q <= fclk_q + FC_W'(1);
      if (line_adv) begin
        phase_q <= PH_W'(phase_sum - inc_v);
      end else if (!last_line) begin
        phase_q <= phase_sum[PH_W-1:0];
      end
    end
  end

endmodule

// File: rtl/raster_line_counter.sv
// Scanline counter with vertical-blank flag and interrupt pulse.
module raster_line_counter #(
  parameter int LINES_A  = 263,
  parameter int LINES_B  = 314,
  parameter int VBL_LINE = 240,
  parameter int LINE_W   = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              std_b,
  input  logic              line_adv,
  input  logic              frame_end,
  output logic [LINE_W-1:0] line_q,
  output logic              last_line,
  output logic              vbl_start,
  output logic              vblank_q,
  output logic              irq_q,
  output logic              tick_q
);

  localparam logic [LINE_W-1:0] LAST_A = LINE_W'(LINES_A - 1);
  localparam logic [LINE_W-1:0] LAST_B = LINE_W'(LINES_B - 1);
  localparam logic [LINE_W-1:0] VBL_V  = LINE_W'(VBL_LINE);

  logic [LINE_W-1:0] line_inc;

  always_comb begin
    line_inc  = line_q + LINE_W'(1);
    last_line = (line_q == (std_b ? LAST_B : LAST_A));
    vbl_start = line_adv && (line_inc == VBL_V);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q   <= '0;
      vblank_q <= 1'b0;
      irq_q    <= 1'b0;
      tick_q   <= 1'b0;
    end else begin
      tick_q <= line_adv | frame_end;
      irq_q  <= vbl_start;
      if (frame_end) begin
        line_q   <= '0;
        vblank_q <= 1'b0;
      end else if (line_adv) begin
        line_q <= line_inc;
        if (vbl_start) vblank_q <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/raster_frame_field.sv
// Frame counter, standard latch, field and line-parity state.
module raster_frame_field
  import raster_seq_pkg::*;
#(
  parameter int FRAME_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               std_sel,
  input  logic [1:0]         ilace_en,
  input  logic               frame_end,
  input  logic               vbl_start,
  output logic               std_b,
  output logic [FRAME_W-1:0] frame_q,
  output logic               field_q,
  output logic               parity_q
);

  vstd_e              std_q;
  logic [FRAME_W-1:0] frame_nxt;
  logic               field_nxt;

  always_comb begin
    frame_nxt = frame_q + FRAME_W'(1);
    field_nxt = (ilace_en == 2'b11) ? frame_nxt[0] : 1'b0;
    std_b     = (std_q == STD_B);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      std_q    <= vstd_e'(std_sel);
      frame_q  <= '0;
      field_q  <= 1'b0;
      parity_q <= 1'b0;
    end else if (frame_end) begin
      std_q    <= vstd_e'(std_sel);
      frame_q  <= frame_nxt;
      field_q  <= field_nxt;
      parity_q <= parity_q ^ field_nxt;
    end else if (vbl_start) begin
      parity_q <= 1'b0;
    end
  end

endmodule

// File: rtl/raster_frame_seq.sv
// Top: video raster line/frame sequencer.
module raster_frame_seq
  import raster_seq_pkg::*;
#(
  parameter int FRAC_W      = 12,
  parameter int INC_A       = 8791293,
  parameter int INC_B       = 8836089,
  parameter int FRAME_CLK_A = 564480,
  parameter int FRAME_CLK_B = 677376,
  parameter int LINES_A     = 263,
  parameter int LINES_B     = 314,
  parameter int VBL_LINE    = 240,
  parameter int FRAME_W     = 16,
  localparam int LINE_W     = $clog2(max_int(LINES_A, LINES_B))
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               std_sel,
  input  logic [1:0]         ilace_en,
  output logic               hsync_tick,
  output logic [LINE_W-1:0]  line_num,
  output logic               vblank,
  output logic               vbl_irq,
  output logic               field,
  output logic [FRAME_W-1:0] frame_cnt,
  output logic [STAT_W-1:0]  status_word
);

  localparam int PH_W = $clog2(max_int(INC_A, INC_B)) + 1;
  localparam int FC_W = $clog2(max_int(FRAME_CLK_A, FRAME_CLK_B));

  logic std_b;
  logic last_line;
  logic line_adv;
  logic frame_end;
  logic vbl_start;
  logic parity;

  raster_line_timer #(
    .FRAC_W(FRAC_W), .INC_A(INC_A), .INC_B(INC_B),
    .FRAME_CLK_A(FRAME_CLK_A), .FRAME_CLK_B(FRAME_CLK_B),
    .PH_W(PH_W), .FC_W(FC_W)
  ) u_timer (
    .clk(clk), .rst(rst), .std_b(std_b), .last_line(last_line),
    .line_adv(line_adv), .frame_end(frame_end)
  );

  raster_line_counter #(
    .LINES_A(LINES_A), .LINES_B(LINES_B), .VBL_LINE(VBL_LINE), .LINE_W(LINE_W)
  ) u_lines (
    .clk(clk), .rst(rst), .std_b(std_b), .line_adv(line_adv),
    .frame_end(frame_end), .line_q(line_num), .last_line(last_line),
    .vbl_start(vbl_start), .vblank_q(vblank), .irq_q(vbl_irq), .tick_q(hsync_tick)
  );

  raster_frame_field #(
    .FRAME_W(FRAME_W)
  ) u_frame (
    .clk(clk), .rst(rst), .std_sel(std_sel), .ilace_en(ilace_en),
    .frame_end(frame_end), .vbl_start(vbl_start), .std_b(std_b),
    .frame_q(frame_cnt), .field_q(field), .parity_q(parity)
  );

  always_comb begin
    status_word                  = '0;
    status_word[STAT_FIELD_BIT]  = field;
    status_word[STAT_PARITY_BIT] = parity;
  end

endmodule

// File: rtl/raster_seq_chk.sv
// Property checker for raster_frame_seq, attached by bind.
module raster_seq_chk #(
  parameter int LINE_W   = 9,
  parameter int FRAME_W  = 16,
  parameter int VBL_LINE = 240
) (
  input logic               clk,
  input logic               rst,
  input logic [1:0]         ilace_en,
  input logic               hsync_tick,
  input logic [LINE_W-1:0]  line_num,
  input logic               vblank,
  input logic               vbl_irq,
  input logic               field,
  input logic [FRAME_W-1:0] frame_cnt
);

  localparam logic [LINE_W-1:0] VBL_V = LINE_W'(VBL_LINE);

  logic wrap;
  assign wrap = hsync_tick && (line_num == '0);

  p_line_step_r2: assert property (@(posedge clk) disable iff (rst)
    (hsync_tick && line_num != '0) |-> (line_num == $past(line_num) + LINE_W'(1)));

  p_line_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !hsync_tick |-> $stable(line_num));

  p_wrap_clears_r3: assert property (@(posedge clk) disable iff (rst)
    wrap |-> !vblank);

  p_vblank_rise_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(vblank) |-> vbl_irq);

  p_irq_single_r6: assert property (@(posedge clk) disable iff (rst)
    vbl_irq |=> !vbl_irq);

  p_irq_line_r6: assert property (@(posedge clk) disable iff (rst)
    vbl_irq |-> (vblank && hsync_tick && line_num == VBL_V));

  p_frame_inc_r7: assert property (@(posedge clk) disable iff (rst)
    wrap |-> (frame_cnt == $past(frame_cnt) + FRAME_W'(1)));

  p_frame_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !wrap |-> $stable(frame_cnt));

  p_field_plain_r8: assert property (@(posedge clk) disable iff (rst)
    (wrap && $past(ilace_en) != 2'b11) |-> !field);

  p_field_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !wrap |-> $stable(field));

endmodule

bind raster_frame_seq raster_seq_chk #(
  .LINE_W(LINE_W), .FRAME_W(FRAME_W), .VBL_LINE(VBL_LINE)
) u_raster_seq_chk (
  .clk(clk), .rst(rst), .ilace_en(ilace_en), .hsync_tick(hsync_tick),
  .line_num(line_num), .vblank(vblank), .vbl_irq(vbl_irq),
  .field(field), .frame_cnt(frame_cnt)
);

// File: tb/test_raster_frame_seq.sv
`timescale 1ns/1ps
module test_raster_frame_seq;

  localparam int FRAC_W  = 12;
  localparam int INC_A   = 22528;  // 5.5 clocks per line
  localparam int INC_B   = 25600;  // 6.25 clocks per line
  localparam int FRM_A   = 56;
  localparam int FRM_B   = 76;
  localparam int LIN_A   = 10;
  localparam int LIN_B   = 12;
  localparam int VBL     = 6;
  localparam int FRAME_W = 4;
  localparam int LINE_W  = 4;

  // {std_sel, ilace_en[1:0], frames[4:0]}
  localparam logic [7:0] VEC_TBL [8] = '{
    {1'b0, 2'b11, 5'd3}, {1'b1, 2'b11, 5'd3}, {1'b0, 2'b01, 5'd2},
    {1'b1, 2'b10, 5'd2}, {1'b0, 2'b00, 5'd2}, {1'b1, 2'b11, 5'd4},
    {1'b0, 2'b11, 5'd4}, {1'b1, 2'b00, 5'd1}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic std_sel = 1'b0;
  logic [1:0] ilace_en = 2'b00;
  logic hsync_tick, vblank, vbl_irq, field;
  logic [LINE_W-1:0] line_num;
  logic [FRAME_W-1:0] frame_cnt;
  logic [31:0] status_word;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  raster_frame_seq #(
    .FRAC_W(FRAC_W), .INC_A(INC_A), .INC_B(INC_B),
    .FRAME_CLK_A(FRM_A), .FRAME_CLK_B(FRM_B),
    .LINES_A(LIN_A), .LINES_B(LIN_B), .VBL_LINE(VBL), .FRAME_W(FRAME_W)
  ) i_raster_frame_seq (
    .clk(clk), .rst(rst), .std_sel(std_sel), .ilace_en(ilace_en),
    .hsync_tick(hsync_tick), .line_num(line_num), .vblank(vblank),
    .vbl_irq(vbl_irq), .field(field), .frame_cnt(frame_cnt),
    .status_word(status_word)
  );

  // reference state
  logic m_std;
  int   m_c;
  int   e_line;
  bit   e_tick, e_irq, e_vbl, e_field, e_par, m_wrap;
  logic [FRAME_W-1:0] e_frame;
  int   wrap_tot;
  int   obs_max;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int lines_begun(input int c, input int tot, input longint inc);
    int n = 0;
    for (int l = 1; l < tot; l++)
      if ((longint'(l) * inc + (64'd1 << FRAC_W) - 1) / (64'd1 << FRAC_W) <= c) n++;
    return n;
  endfunction

  task automatic model_edge();
    int tot, frm, nl;
    longint inc;
    m_wrap = 1'b0;
    if (rst) begin
      m_std = std_sel; m_c = 0; e_line = 0; e_tick = 0; e_irq = 0;
      e_vbl = 0; e_field = 0; e_par = 0; e_frame = '0;
    end else begin
      tot = m_std ? LIN_B : LIN_A;
      frm = m_std ? FRM_B : FRM_A;
      inc = m_std ? INC_B : INC_A;
      if (m_c + 1 == frm) begin
        m_c = 0; nl = 0; m_wrap = 1'b1; wrap_tot = tot;
      end else begin
        m_c++;
        nl = lines_begun(m_c, tot, inc);
      end
      e_tick = (nl != e_line);
      e_irq  = (nl == VBL) && (nl != e_line);
      if (m_wrap) begin
        e_frame = e_frame + 1'b1;
        e_field = (ilace_en == 2'b11) ? e_frame[0] : 1'b0;
        e_par   = e_par ^ e_field;
        e_vbl   = 0;
        m_std   = std_sel;
      end
      if (e_irq) begin
        e_vbl = 1; e_par = 0;
      end
      e_line = nl;
    end
  endtask

  task automatic compare_all();
    if (m_wrap) begin
      check(obs_max == wrap_tot - 1, "R4 frame line total", obs_max + 1, wrap_tot);
      check(line_num == 0 && hsync_tick, "R3 wrap to line 0", line_num, 0);
      obs_max = 0;
    end else if (int'(line_num) > obs_max) begin
      obs_max = int'(line_num);
    end
    check(line_num == LINE_W'(e_line), "R2 line number", line_num, e_line);
    check(hsync_tick == e_tick, "R2 hsync tick", hsync_tick, e_tick);
    check(vblank == e_vbl, "R5 vblank", vblank, e_vbl);
    check(vbl_irq == e_irq, "R6 vblank irq", vbl_irq, e_irq);
    check(frame_cnt == e_frame, "R7 frame count", frame_cnt, e_frame);
    check(field == e_field && status_word[31] == e_field, "R8 field", field, e_field);
    check(status_word[13] == e_par, "R9 parity bit", status_word[13], e_par);
    check((status_word & ~32'h8000_2000) == 0, "R9 other status bits", status_word, 0);
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    if (rst) obs_max = 0;
    else compare_all();
  endtask

  task automatic check_reset_state();
    check(line_num == 0, "R1 line", line_num, 0);
    check(frame_cnt == 0, "R1 frame", frame_cnt, 0);
    check(!field && !vblank && !vbl_irq && !hsync_tick, "R1 flags",
          {field, vblank, vbl_irq, hsync_tick}, 0);
    check(status_word == 0, "R1 status", status_word, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : main
    int len;
    // R1: reset state
    repeat (3) step();
    check_reset_state();
    rst = 1'b0;

    // table-driven frames
    for (int v = 0; v < 8; v++) begin
      int wraps = 0;
      std_sel  = VEC_TBL[v][7];
      ilace_en = VEC_TBL[v][6:5];
      while (wraps < int'(VEC_TBL[v][4:0])) begin
        step();
        if (m_wrap) wraps++;
      end
    end

    // R10: flip the standard mid-frame; the running frame keeps its length
    std_sel = 1'b1; ilace_en = 2'b11;
    do step(); while (!m_wrap);
    do step(); while (!m_wrap);
    len = 0;
    do begin
      step();
      len++;
      if (len == 20) std_sel = 1'b0;
    end while (!m_wrap);
    check(len == FRM_B, "R10 frame length after mid-frame flip", len, FRM_B);
    len = 0;
    do begin step(); len++; end while (!m_wrap);
    check(len == FRM_A, "R3 frame length of new standard", len, FRM_A);

    // R1: reset in the middle of a frame
    repeat (17) step();
    rst = 1'b1;
    repeat (2) step();
    check_reset_state();
    rst = 1'b0;
    do step(); while (!m_wrap);
    do step(); while (!m_wrap);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule